// File: doc/BRIEF.md
# Exception Priority Resolver

This block picks the pending exception that a processor core should service next and works out the priority the core is currently running at. It looks at a table of per-exception state bits (enabled, pending, active) and an 8-bit priority for each exception. From that table it finds the winning pending exception and the most urgent active priority. It then combines the active priority with the core's masking inputs: a fault-level mask, a global mask and a base-priority threshold.

The table holds internal exceptions 1 to 15 and a parameterised number of external interrupt lines. Three internal exceptions have fixed negative priorities, so they always beat every configurable level. A 3-bit split setting chooses how many low priority bits are subpriority. Subpriority bits are dropped before the active level is compared, so they order pending requests but never cause preemption.

All outputs are registered, one cycle after the inputs are sampled. The block produces four results:
- the winning pending exception number;
- the execution priority;
- a flag saying the pending exception may be taken now;
- a request line that asks the core to take an exception. This line ignores all three masking inputs, and the core applies those masks itself.

Top module: `exc_prio_resolver`

## Requirements
- R1: Bit k of the state vectors and bits [8k+7:8k] of the priority vector describe exception k. Exception 0 is never considered. Exceptions 1 to 15 are internal, and external line n is exception n+16.
- R2: `pend_vec` is the number of the enabled and pending exception with the numerically smallest effective priority. On a tie the lowest exception number wins. With no such exception `pend_vec` is 0 and the pending priority is the sentinel 256.
- R3: Exceptions 1, 2 and 3 have fixed priorities -3, -2 and -1, and their priority fields are ignored. Every other exception's priority is its 8-bit field read as unsigned 0..255.
- R4: The active level is the minimum effective priority over active exceptions, or 256 if none is active. The group mask then clears its low `prigroup`+1 bits of the two's-complement value. The same masking is applied to the base-priority threshold.
- R5: `exc_req` is 1 exactly when the pending priority is strictly less than the masked active level. `faultmask`, `primask` and `basepri` have no effect on it.
- R6: `can_take` is 1 exactly when `exec_prio` is strictly greater than the pending priority.
- R7: The running level is:
  - -1 if `faultmask` is set;
  - otherwise 0 if `primask` is set;
  - otherwise the group-masked `basepri` if `basepri` is nonzero;
  - otherwise 256.

  `exec_prio` is the minimum of the running level and the masked active level.
- R8: `exec_prio` is a 10-bit two's-complement value.
- R9: Each output reflects the inputs sampled at the previous rising clock edge and holds until the next edge. While reset is held, `pend_vec`=0, `exec_prio`=256, `can_take`=0 and `exc_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_enabled | input | NUM_EXT+16 | Per-exception enable |
| vec_pending | input | NUM_EXT+16 | Per-exception pending |
| vec_active | input | NUM_EXT+16 | Per-exception active |
| vec_prio | input | 8*(NUM_EXT+16) | Per-exception 8-bit priority fields |
| prigroup | input | 3 | Group/subpriority split |
| faultmask | input | 1 | Raise running level to -1 |
| primask | input | 1 | Raise running level to 0 |
| basepri | input | 8 | Base-priority threshold, 0 = off |
| pend_vec | output | clog2(NUM_EXT+16) | Winning pending exception, 0 = none |
| exec_prio | output | 10 | Execution priority, signed |
| can_take | output | 1 | Pending exception may be taken |
| exc_req | output | 1 | Exception request to the core, masks ignored |

## Verification
A wrong choice of winner shows up at once on `pend_vec`, one clock after the table changes. A wrong tie-break only shows when two enabled, pending entries share a level. A wrong group mask or active minimum shows on `exec_prio`, `exc_req` or both in that same cycle. The mask precedence is visible only on `exec_prio` and `can_take`, because `exc_req` must stay unaffected. For that reason the stimulus toggles the mask inputs while the table stays still, and compares all four outputs every cycle.

// File: rtl/exc_prio_pkg.sv
package exc_prio_pkg;
  localparam int PRIO_W  = 8;
  localparam int SPRIO_W = PRIO_W + 2;
  localparam int PG_W    = 3;
  localparam int N_INT   = 16;

  typedef logic signed [SPRIO_W-1:0] sprio_t;

  localparam sprio_t PRIO_NONE = sprio_t'(256);

  // Clear the low (pg+1) bits of a two's-complement priority.
  function automatic sprio_t grp_mask(sprio_t p, logic [PG_W-1:0] pg);
    sprio_t m;
    m = '1;
    m = m << (int'(pg) + 1);
    return p & m;
  endfunction

  // Effective priority of exception idx given its raw 8-bit field.
  function automatic sprio_t eff_prio(int idx, logic [PRIO_W-1:0] raw);
    case (idx)
      1:       return -sprio_t'(3);
      2:       return -sprio_t'(2);
      3:       return -sprio_t'(1);
      default: return sprio_t'({2'b00, raw});
    endcase
  endfunction
endpackage

// File: rtl/exc_scan.sv
module exc_scan
  import exc_prio_pkg::*;
#(
  parameter int NUM_VEC = 32,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0]        en,
  input  logic [NUM_VEC-1:0]        pend,
  input  logic [NUM_VEC-1:0]        act,
  input  logic [NUM_VEC*PRIO_W-1:0] prio_flat,
  output logic [VEC_W-1:0]          win_vec,
  output sprio_t                    win_prio,
  output sprio_t                    act_min
);
  sprio_t eff [NUM_VEC];

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_eff
    assign eff[g] = eff_prio(g, prio_flat[g*PRIO_W +: PRIO_W]);
  end

  // Linear scan, strict less-than so the lowest index wins ties.
  always_comb begin
    win_vec  = '0;
    win_prio = PRIO_NONE;
    act_min  = PRIO_NONE;
    for (int i = 1; i < NUM_VEC; i++) begin
      if (en[i] && pend[i] && (eff[i] < win_prio)) begin
        win_prio = eff[i];
        win_vec  = VEC_W'(i);
      end
      if (act[i] && (eff[i] < act_min)) begin
        act_min = eff[i];
      end
    end
  end
endmodule

// File: rtl/exc_exec.sv
module exc_exec
  import exc_prio_pkg::*;
(
  input  sprio_t            act_min,
  input  sprio_t            pend_prio,
  input  logic [PG_W-1:0]   prigroup,
  input  logic              faultmask,
  input  logic              primask,
  input  logic [PRIO_W-1:0] basepri,
  output sprio_t            act_grp,
  output sprio_t            exec_prio,
  output logic              can_take,
  output logic              req
);
  sprio_t running;

  always_comb begin
    act_grp = grp_mask(act_min, prigroup);
    if (faultmask)          running = -sprio_t'(1);
    else if (primask)       running = '0;
    else if (basepri != '0) running = grp_mask(sprio_t'({2'b00, basepri}), prigroup);
    else                    running = PRIO_NONE;
    exec_prio = (running < act_grp) ? running : act_grp;
    can_take  = exec_prio > pend_prio;
    req       = pend_prio < act_grp;
  end
endmodule

// File: rtl/exc_prio_resolver.sv
module exc_prio_resolver
  import exc_prio_pkg::*;
#(
  parameter int NUM_EXT  = 16,
  localparam int NUM_VEC = NUM_EXT + N_INT,
  localparam int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_VEC-1:0]        vec_enabled,
  input  logic [NUM_VEC-1:0]        vec_pending,
  input  logic [NUM_VEC-1:0]        vec_active,
  input  logic [NUM_VEC*PRIO_W-1:0] vec_prio,
  input  logic [PG_W-1:0]           prigroup,
  input  logic                      faultmask,
  input  logic                      primask,
  input  logic [PRIO_W-1:0]         basepri,
  output logic [VEC_W-1:0]          pend_vec,
  output logic [SPRIO_W-1:0]        exec_prio,
  output logic                      can_take,
  output logic                      exc_req
);
  logic [VEC_W-1:0] win_vec;
  sprio_t           win_prio, act_min, act_grp, exec_d;
  logic             take_d, req_d;
  sprio_t           pend_prio_q, act_grp_q;

  exc_scan #(.NUM_VEC(NUM_VEC)) u_scan (
    .en(vec_enabled), .pend(vec_pending), .act(vec_active),
    .prio_flat(vec_prio), .win_vec(win_vec), .win_prio(win_prio),
    .act_min(act_min)
  );

  exc_exec u_exec (
    .act_min(act_min), .pend_prio(win_prio), .prigroup(prigroup),
    .faultmask(faultmask), .primask(primask), .basepri(basepri),
    .act_grp(act_grp), .exec_prio(exec_d), .can_take(take_d), .req(req_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vec    <= '0;
      exec_prio   <= PRIO_NONE;
      can_take    <= 1'b0;
      exc_req     <= 1'b0;
      pend_prio_q <= PRIO_NONE;
      act_grp_q   <= PRIO_NONE;
    end else begin
      pend_vec    <= win_vec;
      exec_prio   <= exec_d;
      can_take    <= take_d;
      exc_req     <= req_d;
      pend_prio_q <= win_prio;
      act_grp_q   <= act_grp;
    end
  end

  // R5: a request needs a winner
  p_req_needs_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (pend_vec != '0));
  // R6: taking needs a winner
  p_take_needs_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    can_take |-> (pend_vec != '0));
  // R7: execution level never below the active level
  p_exec_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $signed(exec_prio) <= act_grp_q);
  // R7: fault mask forces level -1 or more urgent
  p_fault_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    faultmask |=> ($signed(exec_prio) <= -10'sd1));
  // R2: no winner means sentinel pending level
  p_none_sentinel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec == '0) |-> (pend_prio_q == PRIO_NONE));
  // R1: winner index within table
  p_vec_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend_vec) < NUM_VEC);
endmodule

// File: tb/exc_prio_resolver_tb.sv
`timescale 1ns/1ps
module exc_prio_resolver_tb;
  localparam int NE = 16;
  localparam int NV = NE + 16;
  localparam int VW = $clog2(NV);

  logic clk = 0, rst_n = 0;
  logic [NV-1:0] en = '0, pd = '0, ac = '0;
  logic [NV*8-1:0] pr = '0;
  logic [2:0] pg = '0;
  logic fm = 0, pm = 0;
  logic [7:0] bp = '0;
  logic [VW-1:0] pend_vec;
  logic [9:0] exec_prio;
  logic can_take, exc_req;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_prio_resolver #(.NUM_EXT(NE)) u_dut (
    .clk(clk), .rst_n(rst_n), .vec_enabled(en), .vec_pending(pd),
    .vec_active(ac), .vec_prio(pr), .prigroup(pg), .faultmask(fm),
    .primask(pm), .basepri(bp), .pend_vec(pend_vec), .exec_prio(exec_prio),
    .can_take(can_take), .exc_req(exc_req)
  );

  function automatic void model(output int pv, output int ep,
                                output bit ct, output bit rq);
    int pp, ap, p, m, run, apg;
    pp = 256; ap = 256; pv = 0;
    for (int i = 1; i < NV; i++) begin
      p = (i == 1) ? -3 : (i == 2) ? -2 : (i == 3) ? -1 : int'(pr[i*8 +: 8]);
      if (en[i] && pd[i] && p < pp) begin pp = p; pv = i; end
      if (ac[i] && p < ap) ap = p;
    end
    m   = -1 << (int'(pg) + 1);
    apg = ap & m;
    run = fm ? -1 : pm ? 0 : (bp != 0) ? (int'(bp) & m) : 256;
    ep  = (run < apg) ? run : apg;
    ct  = ep > pp;
    rq  = pp < apg;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    int pv, ep; bit ct, rq;
    model(pv, ep, ct, rq);
    @(posedge clk); #1;
    chk({req, " pend_vec"}, int'(pend_vec), pv);
    chk({req, " exec_prio"}, int'($signed(exec_prio)), ep);
    chk({req, " can_take"}, int'(can_take), int'(ct));
    chk({req, " exc_req"}, int'(exc_req), int'(rq));
  endtask

  task automatic set_prio(int k, int v);
    pr[k*8 +: 8] = 8'(v);
  endtask

  task automatic clear_tbl();
    en = '0; pd = '0; ac = '0; pr = '0; pg = 0; fm = 0; pm = 0; bp = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    #1;
    // R9 reset values
    chk("R9 reset pend_vec", int'(pend_vec), 0);
    chk("R9 reset exec_prio", int'($signed(exec_prio)), 256);
    chk("R9 reset can_take", int'(can_take), 0);
    chk("R9 reset exc_req", int'(exc_req), 0);
    @(negedge clk); rst_n = 1;

    // R1: external line 0 is exception 16
    @(negedge clk); clear_tbl();
    en[16] = 1; pd[16] = 1; set_prio(16, 40);
    check_all("R1 ext line0");
    chk("R1 ext index", int'(pend_vec), 16);

    // R2: tie, lowest number wins
    @(negedge clk); clear_tbl();
    en[20] = 1; pd[20] = 1; set_prio(20, 7);
    en[18] = 1; pd[18] = 1; set_prio(18, 7);
    check_all("R2 tie");
    chk("R2 tie index", int'(pend_vec), 18);

    // R2: disabled pending ignored, nothing -> 0
    @(negedge clk); clear_tbl();
    pd[25] = 1; set_prio(25, 1);
    check_all("R2 none");
    chk("R2 none index", int'(pend_vec), 0);

    // R3: fixed level beats priority 0 and its field is ignored
    @(negedge clk); clear_tbl();
    en[2] = 1; pd[2] = 1; set_prio(2, 255);
    en[17] = 1; pd[17] = 1; set_prio(17, 0);
    check_all("R3 fixed");
    chk("R3 fixed index", int'(pend_vec), 2);

    // R4: group masking of active level: 0x35 with split 3 -> 0x30
    @(negedge clk); clear_tbl();
    pg = 3; ac[19] = 1; set_prio(19, 8'h35);
    en[21] = 1; pd[21] = 1; set_prio(21, 8'h32);
    check_all("R4 group mask");
    chk("R4 req dropped", int'(exc_req), 0);
    chk("R8 exec signed", int'($signed(exec_prio)), 48);

    // R5: masks do not change exc_req; R7 precedence shows on exec_prio
    @(negedge clk); clear_tbl();
    en[22] = 1; pd[22] = 1; set_prio(22, 10);
    fm = 1; pm = 1; bp = 8'h04;
    check_all("R5 R7 masks");
    chk("R5 req ignores masks", int'(exc_req), 1);
    chk("R7 faultmask wins", int'($signed(exec_prio)), -1);
    @(negedge clk); fm = 0;
    check_all("R7 primask");
    @(negedge clk); pm = 0;
    check_all("R7 basepri");
    chk("R6 take blocked", int'(can_take), 0);
    @(negedge clk); bp = 0;
    check_all("R6 take");
    chk("R6 take open", int'(can_take), 1);

    // R9: output holds until the next edge
    @(negedge clk); en[22] = 0;
    #1 chk("R9 hold", int'(pend_vec), 22);
    check_all("R9 update");

    // Random
    for (int t = 0; t < 1500; t++) begin
      @(negedge clk);
      en = {$urandom, $urandom};
      pd = NV'({$urandom, $urandom}) & NV'({$urandom, $urandom});
      ac = NV'({$urandom, $urandom}) & NV'({$urandom, $urandom})
         & NV'({$urandom, $urandom});
      for (int k = 0; k < NV; k++) set_prio(k, ($urandom % 4 == 0) ? 16 : $urandom);
      pg = 3'($urandom);
      fm = ($urandom % 8) == 0;
      pm = ($urandom % 6) == 0;
      bp = ($urandom % 2) ? 8'($urandom) : 8'h00;
      check_all("R2 R4 R5 R6 R7 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule